// File: doc/BRIEF.md
# Display Memory Write Pointer with Row/Column Scan Order

This block keeps the write position for a byte-organised monochrome frame memory of 84 columns by 6 banks. Each location holds one byte whose eight bits light eight stacked pixels of one bank. A command decoder sets the column and bank coordinates directly and picks the scan order. A stream of display bytes is then written one location after another, with no further addressing needed.

The block drives the memory write port: linear address, data and write enable. It advances the pointer after each stored byte. In row-scan order the column moves first. In column-scan order the bank moves first. Both coordinates have wrap limits that are not powers of two, and the last location of the frame wraps to the origin.

A 504-byte synchronous frame memory is included, with a pixel read port, so that the stored image can be checked by pixel coordinate.

Top module: `dram_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears the column and bank coordinates to 0 and selects row-scan order (`vert_mode` = 0). `wr_en` is 0 while no byte is offered.
- R2: A column load with a value of at most 83 sets `col_ptr` at the next edge. A bank load with a value of at most 5 sets `bank_ptr` at the next edge. Both loads may act in the same cycle.
- R3: In row-scan order each stored byte increments the column. After column 83, the column returns to 0 and the bank increments.
- R4: In column-scan order each stored byte increments the bank and holds the column. After bank 5, the bank returns to 0 and the column increments.
- R5: Storing a byte at column 83, bank 5 moves the pointer to column 0, bank 0 in either scan order.
- R6: While a byte is offered and no coordinate load is present, `wr_en` is 1, `wr_addr` = bank*84 + column and `wr_data` equals `byte_in`.
- R7: The pixel at row r, column c is bit r mod 8 (bit 0 is the top row of a bank) of the byte at bank r/8, column c. `pix_on` shows that pixel one clock after `pix_row`/`pix_col` are presented.
- R8: A column load above 83 or a bank load above 5 leaves that coordinate unchanged. For one cycle after that edge, `load_reject` is 1. Otherwise it is 0.
- R9: When a coordinate load and a byte arrive in the same cycle, the load wins. `wr_en` stays 0, the byte is discarded and the memory is unchanged.
- R10: `col_ptr` never exceeds 83 and `bank_ptr` never exceeds 5.
- R11: `mode_load` sets the scan order from `mode_vertical` at the next edge. A byte stored in that same cycle advances under the old order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| col_load | input | 1 | load column coordinate |
| col_load_val | input | 7 | column value to load |
| bank_load | input | 1 | load bank coordinate |
| bank_load_val | input | 3 | bank value to load |
| mode_load | input | 1 | load scan order |
| mode_vertical | input | 1 | 1 = column-scan order, 0 = row-scan order |
| byte_valid | input | 1 | display byte offered this cycle |
| byte_in | input | 8 | display byte |
| pix_row | input | 6 | pixel row to read |
| pix_col | input | 7 | pixel column to read |
| col_ptr | output | 7 | current column coordinate |
| bank_ptr | output | 3 | current bank coordinate |
| vert_mode | output | 1 | current scan order |
| wr_en | output | 1 | memory write enable |
| wr_addr | output | 9 | linear memory address |
| wr_data | output | 8 | memory write data |
| load_reject | output | 1 | an out-of-range load was ignored in the previous cycle |
| pix_on | output | 1 | pixel value read back |

## Verification
The bench fills the whole frame in row-scan order and checks that the 504th byte returns the pointer to the origin. A design with an off-by-one limit would instead reach column 84 or bank 6 and write outside the frame. It walks column-scan order across the bank-5 and column-83 boundaries and changes the scan order while a byte is being stored. A design that used the new order early would step along the wrong axis. It also issues loads of 84, 127, 6 and 7, and loads that collide with data. A wrong design would clamp or wrap the coordinate, or corrupt memory with a discarded byte. Pixel reads at the top and bottom rows of banks catch a reversed bit order or a wrong bank mapping.

// File: rtl/lcdptr_pkg.sv
// Shared definitions for the display memory write pointer.
// Assumes nothing beyond the standard geometry defaults below.
package lcdptr_pkg;
    localparam int DEF_COLS  = 84;
    localparam int DEF_BANKS = 6;
    localparam int DEF_DW    = 8;

    // Scan order: which coordinate moves first after a stored byte.
    typedef enum logic {
        SCAN_ROW = 1'b0,
        SCAN_COL = 1'b1
    } scan_e;
endpackage

// File: rtl/dram_ptr.sv
// Two-dimensional write pointer. It holds the column and bank coordinates
// and the scan order. It applies direct loads and rejects out-of-range
// values. It advances after each stored byte, with wrap at COLS-1 and BANKS-1.
// Assumes the caller asserts adv only when a byte is really stored.
module dram_ptr
    import lcdptr_pkg::*;
#(
    parameter int COLS  = DEF_COLS,
    parameter int BANKS = DEF_BANKS,
    parameter int XW    = 7,
    parameter int YW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ldx,
    input  logic [XW-1:0] ldx_val,
    input  logic          ldy,
    input  logic [YW-1:0] ldy_val,
    input  logic          mode_ld,
    input  logic          mode_val,
    input  logic          adv,
    output logic [XW-1:0] x_q,
    output logic [YW-1:0] y_q,
    output scan_e         scan_q,
    output logic          reject_q
);
    localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
    localparam logic [YW-1:0] YMAX = YW'(BANKS - 1);

    logic [XW-1:0] x_n;
    logic [YW-1:0] y_n;
    logic          x_bad;
    logic          y_bad;

    // Range check of the requested loads.
    always_comb begin
        x_bad = ldx && (ldx_val > XMAX);
        y_bad = ldy && (ldy_val > YMAX);
    end

    // Next pointer: loads first, otherwise advance in the current order.
    always_comb begin
        x_n = x_q;
        y_n = y_q;
        if (ldx || ldy) begin
            if (ldx && !x_bad) x_n = ldx_val;
            if (ldy && !y_bad) y_n = ldy_val;
        end else if (adv) begin
            if (scan_q == SCAN_ROW) begin
                if (x_q == XMAX) begin
                    x_n = '0;
                    y_n = (y_q == YMAX) ? '0 : y_q + YW'(1);
                end else begin
                    x_n = x_q + XW'(1);
                end
            end else begin
                if (y_q == YMAX) begin
                    y_n = '0;
                    x_n = (x_q == XMAX) ? '0 : x_q + XW'(1);
                end else begin
                    y_n = y_q + YW'(1);
                end
            end
        end
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_n;
            y_q <= y_n;
        end
    end

    // Scan-order register.
    always_ff @(posedge clk) begin
        if (!rst_n)       scan_q <= SCAN_ROW;
        else if (mode_ld) scan_q <= scan_e'(mode_val);
    end

    // One-cycle flag for an ignored out-of-range load.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= x_bad || y_bad;
    end
endmodule

// File: rtl/dram_wport.sv
// Write-port former. It converts the coordinate pair into a linear byte
// address (bank*COLS + column) and gates the write enable against
// coordinate loads. Assumes the coordinates are already in range.
module dram_wport #(
    parameter int COLS = 84,
    parameter int XW   = 7,
    parameter int YW   = 3,
    parameter int AW   = 9,
    parameter int DW   = 8
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          any_load,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_in,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    // Linear address and load-priority write gating.
    always_comb begin
        addr  = AW'(y) * AW'(COLS) + AW'(x);
        we    = byte_valid && !any_load;
        wdata = byte_in;
    end
endmodule

// File: rtl/frame_mem.sv
// Byte-wide frame memory with one synchronous write port and a pixel read
// port. A pixel (row, col) is bit row%DW of byte (row/DW)*COLS + col.
// The read takes one cycle. Coordinates outside the frame read as 0.
// Assumes no read of the location being written in the same cycle.
module frame_mem #(
    parameter int COLS  = 84,
    parameter int BANKS = 6,
    parameter int DW    = 8,
    parameter int AW    = 9,
    parameter int XW    = 7,
    parameter int RW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] row,
    input  logic [XW-1:0] col,
    output logic          pix
);
    localparam int DEPTH = COLS * BANKS;
    localparam int ROWS  = BANKS * DW;
    localparam int BW    = $clog2(DW);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] raddr;
    logic          rvalid;
    logic [DW-1:0] rbyte_q;
    logic [BW-1:0] rbit_q;
    logic          rvalid_q;

    // Read address from pixel coordinates.
    always_comb begin
        raddr  = AW'(row >> BW) * AW'(COLS) + AW'(col);
        rvalid = (32'(row) < ROWS) && (32'(col) < COLS);
    end

    // Byte write.
    always_ff @(posedge clk) begin
        if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    // Registered byte read.
    always_ff @(posedge clk) begin
        rbyte_q <= rvalid ? mem[raddr] : '0;
    end

    // Registered bit select and validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbit_q   <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rbit_q   <= row[BW-1:0];
            rvalid_q <= rvalid;
        end
    end

    // Pixel output.
    always_comb pix = rvalid_q && rbyte_q[rbit_q];
endmodule

// File: rtl/dram_addr_gen.sv
// Top level: display memory write pointer, write-port former and frame
// memory. Coordinate loads take priority over a display byte in the same
// cycle. Assumes the load and byte inputs are synchronous to clk.
module dram_addr_gen
    import lcdptr_pkg::*;
#(
    parameter int COLS  = DEF_COLS,
    parameter int BANKS = DEF_BANKS,
    parameter int DW    = DEF_DW,
    parameter int XW    = $clog2(COLS),
    parameter int YW    = $clog2(BANKS),
    parameter int AW    = $clog2(COLS * BANKS),
    parameter int RW    = $clog2(BANKS * DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_load,
    input  logic [XW-1:0] col_load_val,
    input  logic          bank_load,
    input  logic [YW-1:0] bank_load_val,
    input  logic          mode_load,
    input  logic          mode_vertical,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_in,
    input  logic [RW-1:0] pix_row,
    input  logic [XW-1:0] pix_col,
    output logic [XW-1:0] col_ptr,
    output logic [YW-1:0] bank_ptr,
    output logic          vert_mode,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          load_reject,
    output logic          pix_on
);
    scan_e scan_q;
    logic  any_load;

    // Load presence, shared by pointer and write gating.
    always_comb any_load = col_load || bank_load;

    dram_ptr #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ldx      (col_load),
        .ldx_val  (col_load_val),
        .ldy      (bank_load),
        .ldy_val  (bank_load_val),
        .mode_ld  (mode_load),
        .mode_val (mode_vertical),
        .adv      (wr_en),
        .x_q      (col_ptr),
        .y_q      (bank_ptr),
        .scan_q   (scan_q),
        .reject_q (load_reject)
    );

    dram_wport #(.COLS(COLS), .XW(XW), .YW(YW), .AW(AW), .DW(DW)) u_wport (
        .x          (col_ptr),
        .y          (bank_ptr),
        .any_load   (any_load),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .we         (wr_en),
        .addr       (wr_addr),
        .wdata      (wr_data)
    );

    frame_mem #(.COLS(COLS), .BANKS(BANKS), .DW(DW), .AW(AW), .XW(XW), .RW(RW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .row   (pix_row),
        .col   (pix_col),
        .pix   (pix_on)
    );

    // Scan order made visible.
    always_comb vert_mode = (scan_q == SCAN_COL);
endmodule

// File: rtl/dram_addr_gen_chk.sv
// Property checker for dram_addr_gen, attached by bind below.
module dram_addr_gen_chk #(
    parameter int COLS  = 84,
    parameter int BANKS = 6,
    parameter int XW    = 7,
    parameter int YW    = 3,
    parameter int AW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          col_load,
    input logic [XW-1:0] col_load_val,
    input logic          bank_load,
    input logic [YW-1:0] bank_load_val,
    input logic          vert_mode,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [XW-1:0] col_ptr,
    input logic [YW-1:0] bank_ptr,
    input logic          load_reject
);
    localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
    localparam logic [YW-1:0] YMAX = YW'(BANKS - 1);

    assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ptr <= XMAX) && (bank_ptr <= YMAX));

    assert_addr_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < COLS * BANKS));

    assert_load_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load || bank_load) |-> !wr_en);

    assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !vert_mode && col_ptr == XMAX && bank_ptr != YMAX)
        |=> (col_ptr == '0) && (bank_ptr == $past(bank_ptr) + YW'(1)));

    assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vert_mode && bank_ptr != YMAX)
        |=> (bank_ptr == $past(bank_ptr) + YW'(1)) && $stable(col_ptr));

    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && col_ptr == XMAX && bank_ptr == YMAX)
        |=> (col_ptr == '0) && (bank_ptr == '0));

    assert_bad_col_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && col_load_val > XMAX)
        |=> load_reject && $stable(col_ptr));

    assert_bad_bank_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_load && bank_load_val > YMAX)
        |=> load_reject && $stable(bank_ptr));
endmodule

bind dram_addr_gen dram_addr_gen_chk #(
    .COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW), .AW(AW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_load      (col_load),
    .col_load_val  (col_load_val),
    .bank_load     (bank_load),
    .bank_load_val (bank_load_val),
    .vert_mode     (vert_mode),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .col_ptr       (col_ptr),
    .bank_ptr      (bank_ptr),
    .load_reject   (load_reject)
);

// File: tb/dram_addr_gen_test.sv
`timescale 1ns/1ps
module dram_addr_gen_test;
    localparam int COLS = 84;
    localparam int BANKS = 6;
    localparam int DEPTH = COLS * BANKS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       col_load = 1'b0;
    logic [6:0] col_load_val = '0;
    logic       bank_load = 1'b0;
    logic [2:0] bank_load_val = '0;
    logic       mode_load = 1'b0;
    logic       mode_vertical = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = '0;
    logic [5:0] pix_row = '0;
    logic [6:0] pix_col = '0;
    logic [6:0] col_ptr;
    logic [2:0] bank_ptr;
    logic       vert_mode;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;
    logic       load_reject;
    logic       pix_on;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int         mx, my;
    bit         mv;
    logic [7:0] mmem [DEPTH];

    dram_addr_gen uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lin(input int x, input int y);
        return y * COLS + x;
    endfunction

    // Model of the pointer advance after one stored byte.
    task automatic model_adv();
        if (!mv) begin
            if (mx == COLS - 1) begin mx = 0; my = (my == BANKS - 1) ? 0 : my + 1; end
            else mx = mx + 1;
        end else begin
            if (my == BANKS - 1) begin my = 0; mx = (mx == COLS - 1) ? 0 : mx + 1; end
            else my = my + 1;
        end
    endtask

    // One cycle of stimulus; inputs set after a falling edge, checked before and after the rising edge.
    task automatic step(input bit lx, input int lxv, input bit ly, input int lyv,
                        input bit dv, input int db, input bit ml, input bit mval,
                        input string tag);
        bit exp_we, exp_rej;
        col_load = lx; col_load_val = 7'(lxv);
        bank_load = ly; bank_load_val = 3'(lyv);
        byte_valid = dv; byte_in = 8'(db);
        mode_load = ml; mode_vertical = mval;
        #1;
        exp_we = dv && !(lx || ly);
        chk(wr_en == exp_we, {tag, " R9 wr_en"}, wr_en, exp_we);
        if (exp_we) begin
            chk(wr_addr == 9'(lin(mx, my)), {tag, " R6 wr_addr"}, wr_addr, lin(mx, my));
            chk(wr_data == 8'(db), {tag, " R6 wr_data"}, wr_data, db);
        end
        exp_rej = (lx && lxv > COLS - 1) || (ly && lyv > BANKS - 1);
        if (lx || ly) begin
            if (lx && lxv <= COLS - 1) mx = lxv;
            if (ly && lyv <= BANKS - 1) my = lyv;
        end else if (dv) begin
            mmem[lin(mx, my)] = 8'(db);
            model_adv();
        end
        if (ml) mv = mval;
        @(negedge clk);
        col_load = 0; bank_load = 0; byte_valid = 0; mode_load = 0;
        chk(col_ptr == 7'(mx), {tag, " R2 R10 col_ptr"}, col_ptr, mx);
        chk(bank_ptr == 3'(my), {tag, " R2 R10 bank_ptr"}, bank_ptr, my);
        chk(vert_mode == mv, {tag, " R11 vert_mode"}, vert_mode, mv);
        chk(load_reject == exp_rej, {tag, " R8 load_reject"}, load_reject, exp_rej);
    endtask

    task automatic pix_check(input int r, input int c);
        bit e;
        pix_row = 6'(r); pix_col = 7'(c);
        @(negedge clk);
        e = mmem[lin(c, r / 8)][r % 8];
        chk(pix_on == e, $sformatf("R7 pixel r=%0d c=%0d", r, c), pix_on, e);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd7531));
        mx = 0; my = 0; mv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(col_ptr == 0, "R1 reset col", col_ptr, 0);
        chk(bank_ptr == 0, "R1 reset bank", bank_ptr, 0);
        chk(vert_mode == 0, "R1 reset mode", vert_mode, 0);
        chk(wr_en == 0, "R1 reset wr_en", wr_en, 0);
        @(negedge clk);

        // R3 R5: fill the whole frame in row-scan order.
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, (i * 37 + 5) & 255, 0, 0, "fill R3 R5");
        chk(col_ptr == 0 && bank_ptr == 0, "R5 origin after full frame", {bank_ptr, col_ptr}, 0);

        // R7: bank edge rows and corners.
        pix_check(0, 0); pix_check(7, 0); pix_check(8, 0); pix_check(47, 83);
        pix_check(40, 83); pix_check(23, 42);
        for (int i = 0; i < 40; i++) pix_check($urandom % 48, $urandom % 84);

        // R4 R5 R11: column-scan across bank and column limits.
        step(0, 0, 0, 0, 1, 8'hA5, 1, 1, "mode change R11");
        step(1, 82, 1, 3, 0, 0, 0, 0, "load R2");
        for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, i + 1, 0, 0, "vscan R4 R5");
        step(0, 0, 0, 0, 1, 8'h3C, 1, 0, "mode back R11");
        step(0, 0, 0, 0, 1, 8'h3D, 0, 0, "row after mode R3");

        // R8: out-of-range loads.
        step(1, 84, 0, 0, 0, 0, 0, 0, "col 84 R8");
        step(1, 127, 0, 0, 0, 0, 0, 0, "col 127 R8");
        step(0, 0, 1, 6, 0, 0, 0, 0, "bank 6 R8");
        step(1, 10, 1, 7, 0, 0, 0, 0, "bank 7 col ok R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "idle R8");

        // R9: a load colliding with a byte discards the byte.
        step(1, 5, 1, 2, 1, 8'hFF, 0, 0, "collide R9");
        pix_check(16, 5); pix_check(23, 5);

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            r = $urandom % 100;
            if (r < 70) step(0, 0, 0, 0, 1, $urandom % 256, ($urandom % 20) == 0, $urandom % 2, "rnd write");
            else if (r < 85) step(1, $urandom % 128, ($urandom % 2), $urandom % 8, $urandom % 2, $urandom % 256, 0, 0, "rnd load");
            else step(0, 0, 0, 0, 0, 0, 1, $urandom % 2, "rnd mode");
        end
        for (int i = 0; i < 60; i++) pix_check($urandom % 48, $urandom % 84);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule